// File: doc/BRIEF.md
# Discovery probe match unit

This block is the node-side half of a bus discovery scheme on a shared 9-bit serial bus, where bit 8 of a received word marks an address-select word. It holds an identifier register built from a fixed unique identity, a read-only half-select bit and seven writable address bits. Next to it sit a probe register and a prefix mask register. While the node listens on the reserved discovery address 0xFF, each data word is a probe. The probe writes one probe bit and resets the mask to cover bits 0 up to the probed index. If the identifier and the probe agree under that mask, the block asks for a 0x00 reply.

A probe at the commit index, one past the top of the register, loads the probed address bits into the identifier. It does this only when the node's read-only part agrees with the probe. This is how a master walking the probe register as a stack gives each node its own address. The block also recognises the enter-discovery request sent to the node's own address. It acknowledges selects of lower-half addresses. The reply it requests comes back to the node as an echo, and the block discards that echoed frame, including an errored one.

Top module: `disc_probe_unit`

## Requirements
- R1: After reset, bus_addr reads 0xFF (no address assigned), and reply_req and err_clr are 0.
- R2: A probe word (bit 8 = 0) carries the probe value in bit 7 and the index p in bits 6:0. For p below the register width it sets probe bit p to the value, sets mask bits 0..p and clears every mask bit above p.
- R3: Two clock edges after a probe frame is taken in, reply_req pulses for exactly one cycle if and only if the identifier and the probe register are equal on all masked bits.
- R4: A probe with p equal to the register width and value 1 copies probe bits UID_W+1..UID_W+7 into the writable identifier bits and sets the mask to all ones, provided identifier bits 0..UID_W equal the probe register. bus_addr then reads identifier bit UID_W as bit 7, and identifier bits UID_W+1 through UID_W+7 as bits 6 down to 0.
- R5: A commit probe whose read-only bits disagree with the probe register leaves bus_addr unchanged and gives no reply. A probe with p above the register width, or with p equal to it and value 0, changes nothing and gives no reply.
- R6: A select of 0xFF makes the node take probes only while it has no assigned address or is in discovery mode. A select of any other address ends discovery mode. Data words received while the node is not selected have no effect.
- R7: A node selected by its own address that receives the header 0x1E and then the command 0xFF enters discovery mode, with its probe and mask registers cleared.
- R8: Any other request header with a nonzero count in bits 7:4 causes that many following data words to be skipped, so they are never read as a header or command.
- R9: A select of the node's own address gives a reply when identifier bit UID_W is 0 (lower half) and no reply when it is 1. A select of 0xFF never gives a reply.
- R10: The first frame after a reply request is the echo and is discarded whether it arrives good or errored. If it is errored, err_clr pulses for one cycle after it.
- R11: An errored frame that arrives outside the echo window produces no err_clr and is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a clean received word is on rx_word |
| rx_err | input | 1 | One-cycle strobe: a frame arrived with a framing, overrun or break error |
| rx_word | input | 9 | Received word; bit 8 set marks an address select |
| uid_i | input | UID_W (96) | Fixed unique identity, identifier bits 0..UID_W-1 |
| upper_half_i | input | 1 | Fixed half-select, identifier bit UID_W |
| reply_req | output | 1 | One-cycle request to transmit a 0x00 reply |
| err_clr | output | 1 | One-cycle request to clear the receiver error after an errored echo |
| bus_addr | output | 8 | Current bus address, 0xFF until one is committed |

## Verification
The hardest state to reach from the ports is a node that is already addressed, still holds a full probe pattern, and then must show that the enter-discovery command cleared that pattern. The bench reaches it in steps. It runs a complete stack walk and commit, then selects the node by its new address and sends the enter sequence. It then probes an index where a stale probe register would match and a cleared one cannot. A commit whose read-only prefix has been spoiled is reached the same way: one low probe bit is flipped after the address bits are set. The skip rule is shown when the enter bytes hidden inside a longer request fail to open discovery.

// File: rtl/disc_pkg.sv
package disc_pkg;
   localparam int unsigned WORD_W = 9;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned IDX_W  = 7;

   localparam logic [7:0] HDR_ENTER = 8'h1E;
   localparam logic [7:0] CMD_ENTER = 8'hFF;
   localparam logic [7:0] DISC_SEL  = 8'hFF;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_HDR,
      DS_CMD,
      DS_SKIP,
      DS_PROBE
   } dec_state_t;

   typedef struct packed {
      logic             val;
      logic [IDX_W-1:0] idx;
   } probe_t;
endpackage

// File: rtl/disc_word_dec.sv
module disc_word_dec
   import disc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_v,
   input  logic [WORD_W-1:0] word,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              addr_valid,
   output logic              probe_stb,
   output probe_t            probe,
   output logic              enter_stb,
   output logic              ack_stb
);
   dec_state_t  state_q, state_d;
   logic [3:0]  skip_q, skip_d;
   logic        disc_q, disc_d;
   logic        is_sel;
   logic [7:0]  d;
   logic        listen;

   assign is_sel = word[WORD_W-1];
   assign d      = word[7:0];
   assign listen = disc_q | ~addr_valid;
   assign probe  = probe_t'(d);

   always_comb begin
      state_d   = state_q;
      skip_d    = skip_q;
      disc_d    = disc_q;
      probe_stb = 1'b0;
      enter_stb = 1'b0;
      ack_stb   = 1'b0;
      if (frame_v) begin
         if (is_sel) begin
            if (d == DISC_SEL) begin
               state_d = listen ? DS_PROBE : DS_IDLE;
            end else begin
               disc_d = 1'b0;
               if (addr_valid && d == own_addr) begin
                  state_d = DS_HDR;
                  ack_stb = ~own_addr[ADDR_W-1];
               end else begin
                  state_d = DS_IDLE;
               end
            end
         end else begin
            unique case (state_q)
               DS_PROBE: probe_stb = 1'b1;
               DS_HDR: begin
                  if (d == HDR_ENTER) begin
                     state_d = DS_CMD;
                  end else if (d[7:4] != 4'd0) begin
                     skip_d  = d[7:4];
                     state_d = DS_SKIP;
                  end
               end
               DS_CMD: begin
                  if (d == CMD_ENTER) begin
                     enter_stb = 1'b1;
                     disc_d    = 1'b1;
                  end
                  state_d = DS_HDR;
               end
               DS_SKIP: begin
                  skip_d = skip_q - 4'd1;
                  if (skip_q == 4'd1) state_d = DS_HDR;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         skip_q  <= 4'd0;
         disc_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         skip_q  <= skip_d;
         disc_q  <= disc_d;
      end
   end

   // R7: the enter command leaves the node in discovery mode
   a_r7_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
      enter_stb |=> disc_q);
   // R6: a select of another address drops discovery mode
   a_r6_other_sel_exits: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_v && is_sel && d != DISC_SEL) |=> !disc_q);
   // R8: skipped payload never reaches the command state
   a_r8_skip_no_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DS_SKIP) |-> !enter_stb);
endmodule

// File: rtl/disc_probe_regs.sv
module disc_probe_regs
   import disc_pkg::*;
#(
   parameter int unsigned UID_W      = 96,
   parameter bit          STORE_MASK = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        probe_stb,
   input  probe_t                      probe,
   input  logic [UID_W-1:0]            uid_i,
   input  logic                        upper_half_i,
   output logic [UID_W+ADDR_W-1:0]     ident,
   output logic                        match_pulse,
   output logic                        addr_valid
);
   localparam int unsigned REG_W = UID_W + ADDR_W;
   localparam int unsigned WR_W  = ADDR_W - 1;

   if (UID_W < 1) begin : g_bad_uid
      $error("disc_probe_regs: UID_W must be at least 1");
   end
   if (REG_W + 1 > (1 << IDX_W)) begin : g_bad_width
      $error("disc_probe_regs: commit index does not fit the probe index field");
   end

   logic [REG_W-1:0] p_q;
   logic [REG_W-1:0] mask;
   logic [REG_W-1:0] pre;
   logic [REG_W-1:0] hit;
   logic [WR_W-1:0]  wr_q;
   logic             valid_q;
   logic             done_q;
   logic             in_range;
   logic             at_commit;
   logic             accept;
   logic             ro_eq;
   logic             commit;
   logic [IDX_W-1:0] lim_idx;
   logic             match;

   assign in_range  = probe.idx < IDX_W'(REG_W);
   assign at_commit = (probe.idx == IDX_W'(REG_W)) && probe.val;
   assign accept    = probe_stb && (in_range || at_commit);
   assign lim_idx   = in_range ? probe.idx : IDX_W'(REG_W - 1);
   assign ident     = {wr_q, upper_half_i, uid_i};
   assign ro_eq     = ident[UID_W:0] == p_q[UID_W:0];
   assign commit    = probe_stb && at_commit && ro_eq;

   for (genvar i = 0; i < REG_W; i++) begin : g_bits
      assign pre[i] = IDX_W'(i) <= lim_idx;
      assign hit[i] = probe_stb && in_range && (probe.idx == IDX_W'(i));
   end

   if (STORE_MASK) begin : g_mask_flat
      logic [REG_W-1:0] mask_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) mask_q <= '0;
         else if (accept)   mask_q <= pre;
      end
      assign mask = mask_q;
   end else begin : g_mask_top
      logic [IDX_W-1:0] top_q;
      logic             any_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            top_q <= '0;
            any_q <= 1'b0;
         end else if (accept) begin
            top_q <= lim_idx;
            any_q <= 1'b1;
         end
      end
      for (genvar i = 0; i < REG_W; i++) begin : g_expand
         assign mask[i] = any_q && (IDX_W'(i) <= top_q);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) p_q <= '0;
      else               p_q <= (p_q & ~hit) | (hit & {REG_W{probe.val}});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '1;
         valid_q <= 1'b0;
      end else if (commit) begin
         wr_q    <= p_q[REG_W-1:UID_W+1];
         valid_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) done_q <= 1'b0;
      else               done_q <= accept;
   end

   assign match       = ~|((ident ^ p_q) & mask);
   assign match_pulse = done_q & match;
   assign addr_valid  = valid_q;

   // R7: clearing empties both probe and mask
   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (p_q == '0 && mask == '0));
   // R2: any accepted probe leaves the lowest mask bit set
   a_r2_mask_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !clr) |=> mask[0]);
   // R4: an address only becomes valid through a commit
   a_r4_valid_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(commit));
   // R5: writable bits hold unless a commit occurred
   a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit) |-> $stable(wr_q));
endmodule

// File: rtl/disc_addr_map.sv
module disc_addr_map
   import disc_pkg::*;
#(
   parameter int unsigned UID_W = 96
) (
   input  logic [UID_W+ADDR_W-1:0] ident,
   input  logic                    addr_valid,
   output logic [ADDR_W-1:0]       bus_addr
);
   logic [ADDR_W-1:0] raw;

   for (genvar k = 0; k < ADDR_W; k++) begin : g_rev
      assign raw[ADDR_W-1-k] = ident[UID_W+k];
   end

   assign bus_addr = addr_valid ? raw : '1;
endmodule

// File: rtl/disc_reply_ctl.sv
module disc_reply_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_stb,
   input  logic match_pulse,
   input  logic rx_valid,
   input  logic rx_err,
   output logic echo_pend,
   output logic reply_req,
   output logic err_clr
);
   logic ack_q;
   logic req_d;

   assign req_d = ack_q | match_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         reply_req <= 1'b0;
         echo_pend <= 1'b0;
         err_clr   <= 1'b0;
      end else begin
         ack_q     <= ack_stb;
         reply_req <= req_d;
         err_clr   <= echo_pend & rx_err;
         if (req_d)                                echo_pend <= 1'b1;
         else if (echo_pend && (rx_valid || rx_err)) echo_pend <= 1'b0;
      end
   end

   // R3: each reply request lasts one cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reply_req |=> !reply_req);
   // R10: an error clear only follows a pending echo
   a_r10_clr_after_echo: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |-> $past(echo_pend));
   // R10: the clear is a single pulse
   a_r10_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !err_clr);
endmodule

// File: rtl/disc_probe_unit.sv
module disc_probe_unit
   import disc_pkg::*;
#(
   parameter int unsigned UID_W      = 96,
   parameter bit          STORE_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_err,
   input  logic [8:0]        rx_word,
   input  logic [UID_W-1:0]  uid_i,
   input  logic              upper_half_i,
   output logic              reply_req,
   output logic              err_clr,
   output logic [7:0]        bus_addr
);
   localparam int unsigned REG_W = UID_W + ADDR_W;

   logic              echo_pend;
   logic              frame_v;
   logic              probe_stb;
   probe_t            probe;
   logic              enter_stb;
   logic              ack_stb;
   logic              match_pulse;
   logic              addr_valid;
   logic [REG_W-1:0]  ident;

   assign frame_v = rx_valid & ~echo_pend;

   disc_word_dec u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_v    (frame_v),
      .word       (rx_word),
      .own_addr   (bus_addr),
      .addr_valid (addr_valid),
      .probe_stb  (probe_stb),
      .probe      (probe),
      .enter_stb  (enter_stb),
      .ack_stb    (ack_stb)
   );

   disc_probe_regs #(.UID_W(UID_W), .STORE_MASK(STORE_MASK)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (enter_stb),
      .probe_stb    (probe_stb),
      .probe        (probe),
      .uid_i        (uid_i),
      .upper_half_i (upper_half_i),
      .ident        (ident),
      .match_pulse  (match_pulse),
      .addr_valid   (addr_valid)
   );

   disc_addr_map #(.UID_W(UID_W)) u_map (
      .ident      (ident),
      .addr_valid (addr_valid),
      .bus_addr   (bus_addr)
   );

   disc_reply_ctl u_reply (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_stb     (ack_stb),
      .match_pulse (match_pulse),
      .rx_valid    (rx_valid),
      .rx_err      (rx_err),
      .echo_pend   (echo_pend),
      .reply_req   (reply_req),
      .err_clr     (err_clr)
   );

   // R9: an upper-half node never acknowledges a select
   a_r9_no_upper_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |-> !upper_half_i);
   // R10: the echo frame is never decoded as a probe
   a_r10_echo_not_decoded: assert property (@(posedge clk) disable iff (!rst_n)
      echo_pend |-> !probe_stb);
endmodule

// File: tb/disc_probe_unit_tb.sv
module disc_probe_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int UID_W      = 8;
   localparam int REG_W      = UID_W + 8;
   localparam logic [UID_W-1:0] UID = 8'hB6;
   localparam logic [REG_W-1:0] WR_MASK = {7'h7F, {(UID_W+1){1'b0}}};
   localparam logic [REG_W-1:0] RO_MASK = ~WR_MASK;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic       rx_err = 1'b0;
   logic [8:0] rx_word = '0;
   logic       upper_half = 1'b0;
   logic       reply_req;
   logic       err_clr;
   logic [7:0] bus_addr;

   int checks = 0;
   int failures = 0;

   logic [REG_W-1:0] mP, mM, mI;

   always #(CLK_PERIOD/2) clk = ~clk;

   disc_probe_unit #(.UID_W(UID_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_err       (rx_err),
      .rx_word      (rx_word),
      .uid_i        (UID),
      .upper_half_i (upper_half),
      .reply_req    (reply_req),
      .err_clr      (err_clr),
      .bus_addr     (bus_addr)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mP = '0;
      mM = '0;
      mI = {7'h7F, upper_half, UID};
   endtask

   task automatic send(input logic [8:0] w, input bit err);
      @(negedge clk);
      rx_valid = ~err;
      rx_err   = err;
      rx_word  = w;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_err   = 1'b0;
   endtask

   // send a frame, check the reply, and return the echo if one was requested
   task automatic xfer(input logic [8:0] w, input bit exp, input string tag, output bit got);
      send(w, 1'b0);
      @(negedge clk);
      got = reply_req;
      chk(tag, reply_req, exp);
      if (got) begin
         send(9'h000, 1'b0);
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   function automatic bit mmatch();
      return ((mI ^ mP) & mM) == '0;
   endfunction

   task automatic mprobe(input bit b, input int idx, input string tag, output bit got);
      bit exp;
      if (idx < REG_W) begin
         mP  = (mP & ~(REG_W'(1) << idx)) | (REG_W'(b) << idx);
         mM  = (idx == REG_W - 1) ? '1 : ((REG_W'(1) << (idx + 1)) - REG_W'(1));
         exp = mmatch();
      end else if (idx == REG_W && b) begin
         if (((mI ^ mP) & RO_MASK) == '0) mI = (mI & ~WR_MASK) | (mP & WR_MASK);
         mM  = '1;
         exp = mmatch();
      end else begin
         exp = 1'b0;
      end
      xfer({1'b0, b, 7'(idx)}, exp, tag, got);
   endtask

   task automatic run_discovery(input logic [7:0] addr);
      bit got;
      for (int t = 0; t < REG_W; t++) begin
         mprobe(1'b0, t, "R3 stack advance zero", got);
         if (!got) mprobe(1'b1, t, "R3 stack advance one", got);
      end
      for (int k = 0; k < 7; k++)
         mprobe(bit'((addr >> (6 - k)) & 8'd1), UID_W + 1 + k, "R2 address bit probe", got);
      mprobe(1'b1, REG_W, "R4 commit reply", got);
      chk("R4 committed address", bus_addr, addr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit got;
      do_reset();
      @(negedge clk);
      chk("R1 reset address", bus_addr, 8'hFF);
      chk("R1 reset reply", reply_req, 1'b0);
      chk("R1 reset err_clr", err_clr, 1'b0);

      // R6: unselected data word is ignored
      xfer(9'h000, 1'b0, "R6 unselected data", got);
      // R9: discovery select gets no acknowledge
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);

      // R3/R10: first probe matches; echoed 0x000 must not be decoded
      mprobe(1'b0, 0, "R3 first probe", got);
      @(negedge clk);
      chk("R10 echo discarded", reply_req, 1'b0);

      for (int t = 1; t < REG_W; t++) begin
         mprobe(1'b0, t, "R3 stack advance zero", got);
         if (!got) mprobe(1'b1, t, "R3 stack advance one", got);
      end

      // R5: out-of-range and commit-with-zero probes are ignored
      xfer(9'h0FF, 1'b0, "R5 index above commit", got);
      xfer({2'b00, 7'(REG_W)}, 1'b0, "R5 commit index value 0", got);
      mprobe(1'b1, REG_W - 1, "R5 state kept after ignored probes", got);

      for (int k = 0; k < 7; k++)
         mprobe(bit'((8'h25 >> (6 - k)) & 8'd1), UID_W + 1 + k, "R2 address bit probe", got);
      // R5: spoil a read-only bit then try a commit
      mprobe(~UID[3], 3, "R2 spoiled prefix", got);
      mprobe(1'b1, REG_W, "R5 commit refused", got);
      chk("R5 address unchanged", bus_addr, 8'hFF);
      mprobe(UID[3], 3, "R2 restored prefix", got);
      mprobe(1'b1, REG_W, "R4 commit reply", got);
      chk("R4 committed address", bus_addr, 8'h25);

      // R6: another select ends listening on 0xFF
      xfer(9'h130, 1'b0, "R6 foreign select", got);
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);
      xfer(9'h002, 1'b0, "R6 probe while not listening", got);

      // R9/R10: own select acknowledged; errored echo cleared
      send(9'h125, 1'b0);
      @(negedge clk);
      chk("R9 lower-half ack", reply_req, 1'b1);
      send(9'h000, 1'b1);
      chk("R10 err_clr pulse", err_clr, 1'b1);
      @(negedge clk);
      chk("R10 err_clr one cycle", err_clr, 1'b0);
      send(9'h000, 1'b1);
      chk("R11 stray error", err_clr, 1'b0);

      // R8: enter bytes hidden inside a two-byte request are skipped
      xfer(9'h023, 1'b0, "R8 long header", got);
      xfer(9'h01E, 1'b0, "R8 payload 1", got);
      xfer(9'h0FF, 1'b0, "R8 payload 2", got);
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);
      xfer(9'h081, 1'b0, "R8 no discovery after skip", got);

      // R7: real enter command clears probe and mask
      xfer(9'h125, 1'b1, "R9 lower-half ack", got);
      xfer(9'h01E, 1'b0, "R7 enter header", got);
      xfer(9'h0FF, 1'b0, "R7 enter command", got);
      mP = '0;
      mM = '0;
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);
      mprobe(1'b1, 2, "R7 cleared probe mismatches", got);
      mprobe(1'b1, 1, "R7 rebuilt prefix matches", got);
      xfer(9'h130, 1'b0, "R6 foreign select", got);
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);
      xfer(9'h081, 1'b0, "R6 discovery ended", got);

      // upper-half node
      upper_half = 1'b1;
      do_reset();
      @(negedge clk);
      chk("R1 reset address", bus_addr, 8'hFF);
      xfer(9'h1FF, 1'b0, "R9 no ack on 0xFF", got);
      run_discovery(8'hA7);
      xfer(9'h1A7, 1'b0, "R9 upper-half no ack", got);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule